// File: doc/BRIEF.md
# Full-Bridge Command Decoder with Wake-Up and Thermal Gating

This block converts two logic command inputs into the enables for the four switches of a full bridge. Each side of the bridge, A and B, is a leg with a high-side source switch and a low-side sink switch. With one input high and the other low, current is driven through the load in one direction. With both inputs high, both sink switches close and the load is braked. With both inputs low, every switch is open and the bridge floats. When the host pulse-width modulates one input, this decode gives slow-decay recirculation during the off phase if the other input is held high, and fast decay if the other input is held low. No extra state is needed for either.

Two conditions override the command. The first is the active-low sleep input: while it is low the bridge is off, and after it rises, commands are ignored for a wake-up interval. This interval is derived from a clock-frequency parameter and a delay parameter, and its expiry is reported on `ready`. The second is an 8-bit temperature code in degrees Celsius. It trips a shutdown at a parameterised threshold and releases it only once the code has fallen by a parameterised hysteresis. All outputs are plain control pins sampled on the rising clock edge; no data stream passes through the block.

Top module: `hb_bridge_ctrl`

## Requirements
- R1: With in_a=1 and in_b=0 and the gate open, the edge that samples them sets src_a and snk_b high and src_b and snk_a low.
- R2: With in_a=0 and in_b=1 and the gate open, the edge that samples them sets src_b and snk_a high and src_a and snk_b low.
- R3: With in_a=1 and in_b=1 and the gate open, both sink enables go high and both source enables go low. No current-limit term can remove this state.
- R4: With in_a=0 and in_b=0, all four enables go low at the sampling edge.
- R5: With in_b held high and in_a toggled every cycle (slow decay), the outputs alternate cycle by cycle between the reverse drive state and brake.
- R6: With in_b held low and in_a toggled every cycle (fast decay), the outputs alternate cycle by cycle between the forward drive state and all-off.
- R7: An edge that samples sleep_n=0 forces all enables low and ready low.
- R8: After sleep_n rises, ready goes high only after WAKE_CYC = CLK_MHZ*WAKE_NS/1000 consecutive edges with sleep_n high. Commands sampled before that edge leave all enables low.
- R9: An edge that samples temp_c >= TRIP_C sets therm_shut high and all enables low at that same edge.
- R10: therm_shut clears only at an edge that samples temp_c <= TRIP_C-HYST_C. For codes strictly between the two limits it keeps its previous value.
- R11: The source and sink enables of the same leg are never high together.
- R12: While rst_n is low, all enables, ready and therm_shut are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_a | input | 1 | Command input A |
| in_b | input | 1 | Command input B |
| sleep_n | input | 1 | Active-low sleep request |
| temp_c | input | TEMP_W | Temperature code, unsigned degrees Celsius |
| src_a | output | 1 | High-side enable, leg A |
| src_b | output | 1 | High-side enable, leg B |
| snk_a | output | 1 | Low-side enable, leg A |
| snk_b | output | 1 | Low-side enable, leg B |
| ready | output | 1 | Wake-up interval has elapsed |
| therm_shut | output | 1 | Thermal shutdown active |

## Verification
Every result is due at the first rising edge that samples its stimulus. This holds for the command decode, the sleep gate, the thermal trip and release, and the sleep-driven drop of `ready`. The wake-up rise of `ready` is due WAKE_CYC edges after `sleep_n` is first sampled high, and a command is first honoured one edge later. The bench drives inputs on the falling edge. A reference model steps at each rising edge from the same inputs, and every output is compared against it at the following falling edge, so each check falls exactly one register stage after its cause.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef struct packed {
    logic src_a;
    logic src_b;
    logic snk_a;
    logic snk_b;
  } hb_gate_t;

  localparam hb_gate_t GATE_OFF   = '{src_a: 1'b0, src_b: 1'b0, snk_a: 1'b0, snk_b: 1'b0};
  localparam hb_gate_t GATE_FWD   = '{src_a: 1'b1, src_b: 1'b0, snk_a: 1'b0, snk_b: 1'b1};
  localparam hb_gate_t GATE_REV   = '{src_a: 1'b0, src_b: 1'b1, snk_a: 1'b1, snk_b: 1'b0};
  localparam hb_gate_t GATE_BRAKE = '{src_a: 1'b0, src_b: 1'b0, snk_a: 1'b1, snk_b: 1'b1};
endpackage

// File: rtl/hb_cmd_decode.sv
module hb_cmd_decode
  import hb_pkg::*;
(
  input  logic     in_a,
  input  logic     in_b,
  output hb_gate_t gate
);
  always_comb begin
    unique case ({in_a, in_b})
      2'b10:   gate = GATE_FWD;
      2'b01:   gate = GATE_REV;
      2'b11:   gate = GATE_BRAKE;   // no limiter term on this path (R3)
      default: gate = GATE_OFF;
    endcase
  end
endmodule

// File: rtl/hb_wake_timer.sv
module hb_wake_timer #(
  parameter int CLK_MHZ = 250,
  parameter int WAKE_NS = 1_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n,
  output logic ready
);
  localparam int WAKE_CYC = (CLK_MHZ * WAKE_NS) / 1000;
  localparam int CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] WAKE_LIM = CW'(WAKE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !sleep_n) begin
      cnt_q <= '0;
    end else if (cnt_q != WAKE_LIM) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready = (cnt_q == WAKE_LIM);

  // R8
  ready_after_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> $past(sleep_n));

  // R7
  sleep_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> !ready);
endmodule

// File: rtl/hb_thermal.sv
module hb_thermal #(
  parameter int TEMP_W = 8,
  parameter int TRIP_C = 165,
  parameter int HYST_C = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_c,
  output logic              shut_nxt,
  output logic              shut_q
);
  localparam logic [TEMP_W-1:0] TRIP_LVL = TEMP_W'(TRIP_C);
  localparam logic [TEMP_W-1:0] REL_LVL  = TEMP_W'(TRIP_C - HYST_C);

  always_comb begin
    if (temp_c >= TRIP_LVL)      shut_nxt = 1'b1;
    else if (temp_c <= REL_LVL)  shut_nxt = 1'b0;
    else                         shut_nxt = shut_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) shut_q <= 1'b0;
    else        shut_q <= shut_nxt;
  end

  // R10
  therm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_q && temp_c > REL_LVL) |=> shut_q);

  // R9
  therm_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_c >= TRIP_LVL) |=> shut_q);
endmodule

// File: rtl/hb_bridge_ctrl.sv
module hb_bridge_ctrl
  import hb_pkg::*;
#(
  parameter int CLK_MHZ = 250,
  parameter int WAKE_NS = 1_500_000,
  parameter int TEMP_W  = 8,
  parameter int TRIP_C  = 165,
  parameter int HYST_C  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_a,
  input  logic              in_b,
  input  logic              sleep_n,
  input  logic [TEMP_W-1:0] temp_c,
  output logic              src_a,
  output logic              src_b,
  output logic              snk_a,
  output logic              snk_b,
  output logic              ready,
  output logic              therm_shut
);
  localparam int LEGS = 2;

  hb_gate_t cmd_gate;
  hb_gate_t gate_q;
  logic     wake_ok;
  logic     shut_nxt;
  logic     shut_q;
  logic     drive_en;

  hb_cmd_decode u_dec (
    .in_a (in_a),
    .in_b (in_b),
    .gate (cmd_gate)
  );

  hb_wake_timer #(
    .CLK_MHZ (CLK_MHZ),
    .WAKE_NS (WAKE_NS)
  ) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep_n (sleep_n),
    .ready   (wake_ok)
  );

  hb_thermal #(
    .TEMP_W (TEMP_W),
    .TRIP_C (TRIP_C),
    .HYST_C (HYST_C)
  ) u_therm (
    .clk      (clk),
    .rst_n    (rst_n),
    .temp_c   (temp_c),
    .shut_nxt (shut_nxt),
    .shut_q   (shut_q)
  );

  assign drive_en = sleep_n && wake_ok && !shut_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n)        gate_q <= GATE_OFF;
    else if (drive_en) gate_q <= cmd_gate;
    else               gate_q <= GATE_OFF;
  end

  assign src_a      = gate_q.src_a;
  assign src_b      = gate_q.src_b;
  assign snk_a      = gate_q.snk_a;
  assign snk_b      = gate_q.snk_b;
  assign ready      = wake_ok;
  assign therm_shut = shut_q;

  logic [LEGS-1:0] leg_src;
  logic [LEGS-1:0] leg_snk;
  assign leg_src = {src_b, src_a};
  assign leg_snk = {snk_b, snk_a};

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    // R11
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(leg_src[g] && leg_snk[g]));
  end

  // R7
  sleep_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> (gate_q == GATE_OFF));

  // R9
  shut_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    therm_shut |-> (gate_q == GATE_OFF));

  // R3
  brake_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_a && in_b && drive_en) |=> (snk_a && snk_b && !src_a && !src_b));
endmodule

// File: tb/test_hb_bridge_ctrl.sv
module test_hb_bridge_ctrl;
  localparam int CLK_MHZ = 250;
  localparam int WAKE_NS = 100;
  localparam int W       = (CLK_MHZ * WAKE_NS) / 1000;
  localparam int TRIP    = 165;
  localparam int HYST    = 15;
  localparam int REL     = TRIP - HYST;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_a = 1'b0, in_b = 1'b0, sleep_n = 1'b0;
  logic [7:0] temp_c = 8'd25;
  logic src_a, src_b, snk_a, snk_b, ready, therm_shut;

  int n_chk = 0;
  int n_err = 0;
  string tag = "R12";

  always #2 clk = ~clk;

  hb_bridge_ctrl #(
    .CLK_MHZ (CLK_MHZ), .WAKE_NS (WAKE_NS), .TEMP_W (8),
    .TRIP_C (TRIP), .HYST_C (HYST)
  ) i_hb_bridge_ctrl (
    .clk (clk), .rst_n (rst_n), .in_a (in_a), .in_b (in_b),
    .sleep_n (sleep_n), .temp_c (temp_c),
    .src_a (src_a), .src_b (src_b), .snk_a (snk_a), .snk_b (snk_b),
    .ready (ready), .therm_shut (therm_shut)
  );

  // gate order {src_a, src_b, snk_a, snk_b}
  function automatic logic [3:0] want_gate(logic a, logic b);
    case ({a, b})
      2'b10:   return 4'b1001;
      2'b01:   return 4'b0110;
      2'b11:   return 4'b0011;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic next_shut(logic [7:0] t, logic cur);
    if (t >= TRIP) return 1'b1;
    if (t <= REL)  return 1'b0;
    return cur;
  endfunction

  int         m_cnt = 0;
  logic       m_shut = 1'b0;
  logic [3:0] m_gate = 4'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt  <= 0;
      m_shut <= 1'b0;
      m_gate <= 4'b0;
    end else begin
      m_shut <= next_shut(temp_c, m_shut);
      m_gate <= (sleep_n && m_cnt == W && !next_shut(temp_c, m_shut))
                ? want_gate(in_a, in_b) : 4'b0;
      m_cnt  <= !sleep_n ? 0 : (m_cnt < W ? m_cnt + 1 : m_cnt);
    end
  end

  task automatic check(string t, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", t, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check(tag, {src_a, src_b, snk_a, snk_b}, m_gate);
    check(rst_n ? "R8" : "R12", ready, (rst_n && m_cnt == W));
    check(rst_n ? "R10" : "R12", therm_shut, m_shut);
    check("R11", (src_a & snk_a) | (src_b & snk_b), 0);
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cmd(logic a, logic b, int n);
    in_a = a; in_b = b; step(n);
  endtask

  initial begin
    void'($urandom(32'd1234));
    tag = "R12";
    step(4);
    rst_n = 1'b1; sleep_n = 1'b1; in_a = 1'b1; in_b = 1'b0;
    tag = "R8";
    step(W + 3);
    tag = "R1"; cmd(1, 0, 4);
    tag = "R2"; cmd(0, 1, 4);
    tag = "R3"; cmd(1, 1, 4);
    tag = "R4"; cmd(0, 0, 4);
    tag = "R5";
    for (int i = 0; i < 16; i++) cmd(i[0], 1, 1);
    tag = "R6";
    for (int i = 0; i < 16; i++) cmd(i[0], 0, 1);
    tag = "R7"; in_a = 1'b1; in_b = 1'b0; sleep_n = 1'b0; step(5);
    tag = "R8"; sleep_n = 1'b1; step(W + 4);
    tag = "R9";
    temp_c = 8'd160; step(2);
    temp_c = 8'd165; step(3);
    temp_c = 8'd200; step(2);
    tag = "R10";
    temp_c = 8'd155; step(2);
    temp_c = 8'd151; step(2);
    temp_c = 8'd150; step(2);
    temp_c = 8'd160; step(2);
    temp_c = 8'd149; step(2);
    tag = "R11";
    for (int i = 0; i < 3000; i++) begin
      in_a = 1'($urandom);
      in_b = 1'($urandom);
      if ($urandom_range(0, 99) < 2) sleep_n = ~sleep_n;
      else if (!sleep_n && $urandom_range(0, 9) < 3) sleep_n = 1'b1;
      temp_c = 8'($urandom_range(140, 175));
      step(1);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule